// File: doc/BRIEF.md
# Prioritised Interrupt Request and Chained Acknowledge Slave

This block is the interrupt half of a slave on a multiplexed address/data bus. Software or local logic posts an interrupt event. The block then drives a fixed set of bus request lines that encodes one of four priority levels, 4 through 7. Each higher level adds lines to those below it instead of using a single line of its own. When the bus master later runs an acknowledge cycle, it raises the read strobe first and then sends the acknowledge down a daisy chain of slaves. Each slave either claims the acknowledge or passes it downstream.

The claim-or-pass decision is registered at the rising edge of the read strobe, which is well before the acknowledge arrives. The registered decision does not change after that edge. If a request line of higher priority than this device is active at that edge, the device passes the acknowledge on, even when it is requesting itself. A claiming device raises reply and places its interrupt vector on the data lines at once. It releases both when the read strobe drops, and it then withdraws its request. A passing device holds acknowledge-out until acknowledge-in falls. The vector comes either from a switch input or from a software-written register. The DMA grant chain passes straight through the block.

All bus signals are shown here in positive polarity (1 means asserted), on the inner side of the inverting transceivers.

Top module: `irq_chain_slave`

## Requirements
- R1: Request lines are numbered irq_out[0]..irq_out[3] for levels 4..7. cfg_level 0..3 selects level 4..7. While a request is pending, irq_out is 4'b0001 for level 4, 4'b0011 for level 5, 4'b0101 for level 6 and 4'b1101 for level 7. With no request pending, irq_out is 4'b0000. irq_out follows the pending state one clock edge after the event that changes it.
- R2: A one-cycle pulse on irq_post sets the pending request at the next edge. The request stays set through any number of passed acknowledges. Only the completion of a claimed acknowledge clears it.
- R3: At the clock edge where din is first seen high, the block records a claim decision. It claims only if a request is pending and none of the lines above its level is active on irq_in. The lines checked are irq_in[1] and irq_in[2] at level 4, irq_in[2] at level 5, and irq_in[3] at level 6. No lines are checked at level 7. In every other case it passes the acknowledge.
- R4: Changes to irq_in after the rising edge of din do not alter the recorded decision for that strobe.
- R5: With no request pending, the block always passes the acknowledge and never raises rply.
- R6: When passing, iak_out rises one edge after iak_in is seen high with a recorded decision present. It stays high while iak_in stays high, even if din has fallen. It falls one edge after iak_in falls. rply stays low throughout.
- R7: When claiming, rply and dal_oe rise at the same edge at which iak_out would have risen. dal_out carries the vector from that same edge onward, and iak_out stays low.
- R8: One edge after din falls during a claim, rply and dal_oe drop, dal_out returns to zero and the pending request clears. dal_out is zero whenever dal_oe is low.
- R9: The vector is taken from the register when vec_sel is 1 and from vec_sw when vec_sel is 0. A pulse on vec_wr_en loads vec_wr_data into the register. The vector is captured when the claim starts, so later changes to vec_sw do not reach dal_out during that claim.
- R10: Bus reset (rst_n low) clears the pending request, the recorded decision, rply, iak_out and dal_oe. It also returns the vector register to VEC_RST.
- R11: dmg_out equals dmg_in at all times.
- R12: If irq_post is pulsed in the same cycle that a claim completes, the new request wins and stays pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Bus reset, active low, asynchronous |
| cfg_level | input | 2 | Priority level minus 4 |
| irq_post | input | 1 | Interrupt event pulse |
| vec_sel | input | 1 | 1 selects the vector register, 0 selects the switches |
| vec_sw | input | DAL_W | Switch vector |
| vec_wr_en | input | 1 | Vector register write strobe |
| vec_wr_data | input | DAL_W | Vector register write data |
| irq_in | input | 4 | Request lines observed on the bus |
| irq_out | output | 4 | Request lines driven by this device |
| din | input | 1 | Read strobe from the master |
| iak_in | input | 1 | Acknowledge arriving from upstream |
| iak_out | output | 1 | Acknowledge passed downstream |
| rply | output | 1 | Slave reply |
| dal_out | output | DAL_W | Vector driven onto the data lines |
| dal_oe | output | 1 | Data line drive enable |
| dmg_in | input | 1 | DMA grant from upstream |
| dmg_out | output | 1 | DMA grant passed downstream |

## Verification
Inputs change on the falling clock edge, and each result is sampled on the next falling edge after the rising edge that produces it. irq_out is checked one edge after irq_post. The decision is recorded one edge after din rises, and rply or iak_out is checked one edge after iak_in rises. The release of rply, dal_oe and the pending request is checked one edge after din falls, and the drop of iak_out one edge after iak_in falls. dmg_out is combinational and is checked within the same cycle.

// File: rtl/irq_chain_pkg.sv
package irq_chain_pkg;

   localparam int NUM_LINES = 4;

   typedef enum logic [1:0] {
      ACK_IDLE  = 2'd0,
      ACK_CLAIM = 2'd1,
      ACK_PASS  = 2'd2
   } ack_state_t;

   // cumulative line pattern for a level (index 0 = level 4)
   function automatic logic [NUM_LINES-1:0] lines_for_level(input logic [1:0] lvl);
      logic [NUM_LINES-1:0] r;
      case (lvl)
         2'd0:    r = 4'b0001;
         2'd1:    r = 4'b0011;
         2'd2:    r = 4'b0101;
         default: r = 4'b1101;
      endcase
      return r;
   endfunction

   // higher-priority lines that force the acknowledge downstream
   function automatic logic [NUM_LINES-1:0] yield_mask(input logic [1:0] lvl);
      logic [NUM_LINES-1:0] r;
      case (lvl)
         2'd0:    r = 4'b0110;
         2'd1:    r = 4'b0100;
         2'd2:    r = 4'b1000;
         default: r = 4'b0000;
      endcase
      return r;
   endfunction

endpackage

// File: rtl/irq_lvl_encoder.sv
module irq_lvl_encoder
   import irq_chain_pkg::*;
#(
   parameter int LINES = NUM_LINES
) (
   input  logic [1:0]       lvl,
   input  logic             active,
   output logic [LINES-1:0] lines_out,
   output logic [LINES-1:0] check_mask
);

   localparam logic [LINES-1:0] ZERO = '0;

   if (LINES != NUM_LINES) begin : g_bad_lines
      $error("irq_lvl_encoder: LINES must equal NUM_LINES");
   end

   logic [LINES-1:0] pattern;

   always_comb begin
      pattern    = lines_for_level(lvl);
      check_mask = yield_mask(lvl);
   end

   for (genvar i = 0; i < LINES; i++) begin : g_line
      assign lines_out[i] = active & pattern[i];
   end

   // every active pattern includes the lowest line (R1)
   always_comb begin
      if (lines_out != ZERO) begin
         a_low_line_r1: assert (lines_out[0]) else $error("R1 pattern lacks lowest line");
      end
   end

endmodule

// File: rtl/irq_vec_src.sv
module irq_vec_src #(
   parameter int               DAL_W       = 16,
   parameter bit               HAS_VEC_REG = 1'b1,
   parameter logic [DAL_W-1:0] VEC_RST     = '0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic [DAL_W-1:0] wr_data,
   input  logic             sel,
   input  logic [DAL_W-1:0] sw,
   output logic [DAL_W-1:0] vec
);

   if (HAS_VEC_REG) begin : g_reg
      logic [DAL_W-1:0] vec_q;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)     vec_q <= VEC_RST;
         else if (wr_en) vec_q <= wr_data;
      end

      assign vec = sel ? vec_q : sw;

      p_wr_load_r9: assert property (@(posedge clk) disable iff (!rst_n)
         wr_en |=> vec_q == $past(wr_data))
         else $error("R9 vector register did not load");
   end else begin : g_sw_only
      assign vec = sw;
   end

endmodule

// File: rtl/irq_ack_fsm.sv
module irq_ack_fsm
   import irq_chain_pkg::*;
#(
   parameter int DAL_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             din,
   input  logic             iak_in,
   input  logic             want_claim,
   input  logic [DAL_W-1:0] vec,
   output logic             rply,
   output logic             iak_out,
   output logic [DAL_W-1:0] dal_out,
   output logic             dal_oe,
   output logic             claim_done
);

   ack_state_t       state_q;
   logic             din_q;
   logic             dec_valid_q;
   logic             dec_claim_q;
   logic [DAL_W-1:0] vec_hold_q;
   logic             din_lead;

   assign din_lead = din & ~din_q;

   // decision frozen at the strobe's leading edge
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         din_q       <= 1'b0;
         dec_valid_q <= 1'b0;
         dec_claim_q <= 1'b0;
      end else begin
         din_q <= din;
         if (din_lead) begin
            dec_valid_q <= 1'b1;
            dec_claim_q <= want_claim;
         end else if (!din) begin
            dec_valid_q <= 1'b0;
            dec_claim_q <= 1'b0;
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q    <= ACK_IDLE;
         vec_hold_q <= '0;
      end else begin
         case (state_q)
            ACK_IDLE: begin
               if (dec_valid_q && din && iak_in) begin
                  if (dec_claim_q) begin
                     state_q    <= ACK_CLAIM;
                     vec_hold_q <= vec;
                  end else begin
                     state_q <= ACK_PASS;
                  end
               end
            end
            ACK_CLAIM: if (!din)    state_q <= ACK_IDLE;
            ACK_PASS:  if (!iak_in) state_q <= ACK_IDLE;
            default:   state_q <= ACK_IDLE;
         endcase
      end
   end

   assign rply       = (state_q == ACK_CLAIM);
   assign dal_oe     = rply;
   assign dal_out    = rply ? vec_hold_q : '0;
   assign iak_out    = (state_q == ACK_PASS);
   assign claim_done = rply & ~din;

   p_pass_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
      iak_out && iak_in |=> iak_out)
      else $error("R6 acknowledge-out dropped while acknowledge-in held");

   p_pass_needs_iak_r6: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(iak_out) |-> $past(iak_in))
      else $error("R6 acknowledge-out without acknowledge-in");

   p_claim_needs_iak_r7: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rply) |-> $past(iak_in) && $past(din))
      else $error("R7 reply without acknowledge");

   p_release_r8: assert property (@(posedge clk) disable iff (!rst_n)
      rply && !din |=> !rply && !dal_oe)
      else $error("R8 reply held after strobe fell");

   p_vec_stable_r9: assert property (@(posedge clk) disable iff (!rst_n)
      rply && $past(rply) |-> $stable(dal_out))
      else $error("R9 vector moved during claim");

endmodule

// File: rtl/irq_chain_slave.sv
module irq_chain_slave
   import irq_chain_pkg::*;
#(
   parameter int               DAL_W       = 16,
   parameter bit               HAS_VEC_REG = 1'b1,
   parameter logic [DAL_W-1:0] VEC_RST     = 16'h00C0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [1:0]       cfg_level,
   input  logic             irq_post,
   input  logic             vec_sel,
   input  logic [DAL_W-1:0] vec_sw,
   input  logic             vec_wr_en,
   input  logic [DAL_W-1:0] vec_wr_data,
   input  logic [3:0]       irq_in,
   output logic [3:0]       irq_out,
   input  logic             din,
   input  logic             iak_in,
   output logic             iak_out,
   output logic             rply,
   output logic [DAL_W-1:0] dal_out,
   output logic             dal_oe,
   input  logic             dmg_in,
   output logic             dmg_out
);

   if (DAL_W < 8) begin : g_bad_width
      $error("irq_chain_slave: DAL_W must be at least 8");
   end

   logic             pend_q;
   logic             claim_done;
   logic             want_claim;
   logic [3:0]       check_mask;
   logic [DAL_W-1:0] vec;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          pend_q <= 1'b0;
      else if (irq_post)   pend_q <= 1'b1;
      else if (claim_done) pend_q <= 1'b0;
   end

   irq_lvl_encoder #(.LINES(NUM_LINES)) u_enc (
      .lvl        (cfg_level),
      .active     (pend_q),
      .lines_out  (irq_out),
      .check_mask (check_mask)
   );

   assign want_claim = pend_q & ~(|(irq_in & check_mask));

   irq_vec_src #(
      .DAL_W       (DAL_W),
      .HAS_VEC_REG (HAS_VEC_REG),
      .VEC_RST     (VEC_RST)
   ) u_vec (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (vec_wr_en),
      .wr_data (vec_wr_data),
      .sel     (vec_sel),
      .sw      (vec_sw),
      .vec     (vec)
   );

   irq_ack_fsm #(.DAL_W(DAL_W)) u_fsm (
      .clk        (clk),
      .rst_n      (rst_n),
      .din        (din),
      .iak_in     (iak_in),
      .want_claim (want_claim),
      .vec        (vec),
      .rply       (rply),
      .iak_out    (iak_out),
      .dal_out    (dal_out),
      .dal_oe     (dal_oe),
      .claim_done (claim_done)
   );

   assign dmg_out = dmg_in;

   p_post_sets_r2: assert property (@(posedge clk) disable iff (!rst_n)
      irq_post |=> irq_out != 4'b0000)
      else $error("R2 post did not raise request");

   p_clear_on_done_r8: assert property (@(posedge clk) disable iff (!rst_n)
      rply && !din && !irq_post |=> irq_out == 4'b0000)
      else $error("R8 request not withdrawn after claim");

   p_claim_needs_pend_r5: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rply) |-> $past(pend_q))
      else $error("R5 claim without pending request");

   p_post_wins_r12: assert property (@(posedge clk) disable iff (!rst_n)
      irq_post && rply && !din |=> pend_q)
      else $error("R12 coincident post lost");

endmodule

// File: tb/irq_chain_slave_tb_top.sv
module irq_chain_slave_tb_top;

   localparam int CLK_PERIOD = 10;
   localparam int DAL_W      = 16;
   localparam logic [DAL_W-1:0] VRST = 16'h00C0;

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic [1:0]       cfg_level = 2'd0;
   logic             irq_post = 1'b0;
   logic             vec_sel = 1'b0;
   logic [DAL_W-1:0] vec_sw = '0;
   logic             vec_wr_en = 1'b0;
   logic [DAL_W-1:0] vec_wr_data = '0;
   logic [3:0]       irq_in = '0;
   logic [3:0]       irq_out;
   logic             din = 1'b0;
   logic             iak_in = 1'b0;
   logic             iak_out;
   logic             rply;
   logic [DAL_W-1:0] dal_out;
   logic             dal_oe;
   logic             dmg_in = 1'b0;
   logic             dmg_out;

   int checks = 0;
   int errors = 0;
   int cycles = 0;
   logic             m_pend = 1'b0;
   logic [DAL_W-1:0] m_vreg = VRST;

   always #(CLK_PERIOD/2) clk = ~clk;

   irq_chain_slave #(.DAL_W(DAL_W), .HAS_VEC_REG(1'b1), .VEC_RST(VRST)) dut_i (
      .clk(clk), .rst_n(rst_n), .cfg_level(cfg_level), .irq_post(irq_post),
      .vec_sel(vec_sel), .vec_sw(vec_sw), .vec_wr_en(vec_wr_en),
      .vec_wr_data(vec_wr_data), .irq_in(irq_in), .irq_out(irq_out),
      .din(din), .iak_in(iak_in), .iak_out(iak_out), .rply(rply),
      .dal_out(dal_out), .dal_oe(dal_oe), .dmg_in(dmg_in), .dmg_out(dmg_out)
   );

   function automatic logic [3:0] f_lines(input logic [1:0] l, input logic p);
      logic [3:0] r;
      r = (l == 2'd0) ? 4'b0001 : (l == 2'd1) ? 4'b0011 :
          (l == 2'd2) ? 4'b0101 : 4'b1101;
      return p ? r : 4'b0000;
   endfunction

   function automatic logic f_claim(input logic [1:0] l, input logic p, input logic [3:0] ob);
      logic [3:0] m;
      m = (l == 2'd0) ? 4'b0110 : (l == 2'd1) ? 4'b0100 :
          (l == 2'd2) ? 4'b1000 : 4'b0000;
      return p && ((ob & m) == 4'b0000);
   endfunction

   task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
      end
   endtask

   task automatic report();
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   endtask

   task automatic post();
      irq_post = 1'b1;
      @(negedge clk);
      irq_post = 1'b0;
      m_pend = 1'b1;
   endtask

   task automatic write_vec(input logic [DAL_W-1:0] v);
      vec_wr_data = v;
      vec_wr_en = 1'b1;
      @(negedge clk);
      vec_wr_en = 1'b0;
      m_vreg = v;
   endtask

   // full acknowledge cycle; ob = lines at strobe edge, oa = lines afterwards
   task automatic ack_cycle(input logic [3:0] ob, input logic [3:0] oa);
      logic             claim;
      logic [DAL_W-1:0] ev;
      claim = f_claim(cfg_level, m_pend, ob);
      ev = vec_sel ? m_vreg : vec_sw;
      irq_in = ob;
      din = 1'b1;
      @(negedge clk);
      irq_in = oa;
      iak_in = 1'b1;
      @(negedge clk);
      if (claim) begin
         chk(rply === 1'b1, "R3/R7 rply on claim", rply, 1);
         chk(iak_out === 1'b0, "R7 iak_out low on claim", iak_out, 0);
         chk(dal_oe === 1'b1 && dal_out === ev, "R7/R9 vector on claim", dal_out, ev);
         din = 1'b0;
         @(negedge clk);
         m_pend = 1'b0;
         chk(rply === 1'b0 && dal_oe === 1'b0, "R8 release", {rply, dal_oe}, 0);
         chk(dal_out === '0, "R8 dal_out zero", dal_out, 0);
         chk(irq_out === 4'b0000, "R8 request withdrawn", irq_out, 0);
         iak_in = 1'b0;
      end else begin
         chk(iak_out === 1'b1, "R3/R5/R6 pass", iak_out, 1);
         chk(rply === 1'b0, "R6 no rply on pass", rply, 0);
         din = 1'b0;
         @(negedge clk);
         chk(iak_out === 1'b1, "R6 held while iak_in high", iak_out, 1);
         chk(irq_out === f_lines(cfg_level, m_pend), "R2 request kept after pass",
             irq_out, f_lines(cfg_level, m_pend));
         iak_in = 1'b0;
         @(negedge clk);
         chk(iak_out === 1'b0, "R6 drop after iak_in", iak_out, 0);
      end
      irq_in = '0;
      @(negedge clk);
   endtask

   initial begin : watchdog
      forever begin
         @(posedge clk);
         cycles++;
         if (cycles > 100000) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired actual=%0d expected<=100000", cycles);
            report();
         end
      end
   end

   initial begin : stim
      logic [31:0] seed;
      seed = $urandom(32'd4711);
      repeat (3) @(negedge clk);
      // R10 reset state
      chk(irq_out === 4'b0000 && rply === 1'b0 && iak_out === 1'b0 && dal_oe === 1'b0,
          "R10 reset outputs", {irq_out, rply, iak_out, dal_oe}, 0);
      rst_n = 1'b1;
      @(negedge clk);

      // R11 grant pass-through
      dmg_in = 1'b1; #1;
      chk(dmg_out === 1'b1, "R11 grant high", dmg_out, 1);
      dmg_in = 1'b0; #1;
      chk(dmg_out === 1'b0, "R11 grant low", dmg_out, 0);

      // R1 each level encoding
      for (int l = 0; l < 4; l++) begin
         cfg_level = l[1:0];
         @(negedge clk);
         chk(irq_out === 4'b0000, "R1 idle lines", irq_out, 0);
         post();
         chk(irq_out === f_lines(cfg_level, 1'b1), "R1 level pattern", irq_out, f_lines(cfg_level, 1'b1));
         ack_cycle(4'b0000, 4'b0000);
      end

      // R5 no request -> pass
      cfg_level = 2'd3;
      ack_cycle(4'b0000, 4'b0000);

      // R4 freeze: clear at edge, higher line appears later -> still claim
      cfg_level = 2'd0;
      post();
      ack_cycle(4'b0000, 4'b0110);
      // R4 freeze: higher at edge, removed later -> still pass, request remains
      post();
      ack_cycle(4'b0100, 4'b0000);
      chk(irq_out === 4'b0001, "R4/R2 still pending", irq_out, 4'b0001);
      ack_cycle(4'b0000, 4'b0000);

      // R9 register vs switch, and capture at claim start
      write_vec(16'h0134);
      vec_sel = 1'b1;
      post();
      ack_cycle(4'b0000, 4'b0000);
      vec_sel = 1'b0;
      vec_sw = 16'h00A8;
      post();
      din = 1'b1;
      @(negedge clk);
      iak_in = 1'b1;
      @(negedge clk);
      chk(dal_out === 16'h00A8, "R9 switch vector", dal_out, 16'h00A8);
      vec_sw = 16'h0FF0;
      @(negedge clk);
      chk(dal_out === 16'h00A8, "R9 vector captured", dal_out, 16'h00A8);
      // R12 post coincident with completion
      din = 1'b0;
      irq_post = 1'b1;
      @(negedge clk);
      irq_post = 1'b0;
      iak_in = 1'b0;
      chk(rply === 1'b0, "R12 claim ended", rply, 0);
      chk(irq_out === 4'b0001, "R12 new request kept", irq_out, 4'b0001);
      m_pend = 1'b1;
      @(negedge clk);

      // R10 reset in mid claim
      vec_sel = 1'b1;
      din = 1'b1;
      @(negedge clk);
      iak_in = 1'b1;
      @(negedge clk);
      chk(rply === 1'b1, "R10 precondition claim", rply, 1);
      rst_n = 1'b0;
      @(negedge clk);
      chk(rply === 1'b0 && dal_oe === 1'b0 && iak_out === 1'b0 && irq_out === 4'b0000,
          "R10 reset clears", {rply, dal_oe, iak_out, irq_out}, 0);
      din = 1'b0;
      iak_in = 1'b0;
      rst_n = 1'b1;
      m_pend = 1'b0;
      m_vreg = VRST;
      @(negedge clk);
      post();
      ack_cycle(4'b0000, 4'b0000);

      // random mix
      for (int i = 0; i < 300; i++) begin
         cfg_level = 2'($urandom_range(0, 3));
         vec_sel = 1'($urandom_range(0, 1));
         vec_sw = 16'($urandom);
         if ($urandom_range(0, 3) == 0) write_vec(16'($urandom));
         if ($urandom_range(0, 1) == 1) post();
         else @(negedge clk);
         chk(irq_out === f_lines(cfg_level, m_pend), "R1 random pattern",
             irq_out, f_lines(cfg_level, m_pend));
         ack_cycle(4'($urandom), 4'($urandom));
      end

      report();
   end

endmodule